// File: doc/BRIEF.md
# ROM-to-FIFO Write Sequencer

This block reads a table of constant words out of a small on-chip lookup ROM and pushes them, one by one and in address order, into the write port of a FIFO. A four-state machine alternates between a cycle that raises the write request and a cycle that advances the ROM address. Because the ROM is combinational, the word for the current address is on the FIFO data input directly, with no pipeline register, and it has been stable for at least a full cycle before the capturing edge.

The sequencer watches the FIFO full flag before every write. While the flag is high it waits in its current non-writing state with the address held. After the word at the last address has been written, it parks in a finished state, raises a done flag and issues no further writes until the next reset. A full sweep writes exactly 2^ADDR_W words. With the default of 8 address bits that is 256 words, and the first one is the constant 1.

Top module: `rom_fifo_writer`

## Requirements
- R1: A rising clock edge with `rst_n` low leaves `wr_req` low, `rom_addr` at 0 and `done` low in the following cycle, whatever state the block was in before.
- R2: `wr_data` always equals the ROM entry for the current `rom_addr` in the same cycle, with entry k = (k * SEED + 1) mod 2^DATA_W and SEED = 0x9E3779B9 by default, so entry 0 is 1.
- R3: After reset is released, the first rising edge that samples `fifo_full` low makes `wr_req` high in the following cycle, with `rom_addr` still at 0.
- R4: `rom_addr` in every cycle with `wr_req` high equals its value in the cycle before, so the data word is stable for two cycles up to the capturing edge.
- R5: After a write cycle at an address below the last one, the next cycle has `wr_req` low and `rom_addr` one higher.
- R6: `wr_req` is high only after a rising edge that sampled `fifo_full` low. While `fifo_full` is sampled high outside a write cycle, `wr_req` stays low and `rom_addr` holds its value.
- R7: `wr_req` is never high in two consecutive cycles. With `fifo_full` held low, the 2^ADDR_W write cycles of a sweep run from the first to the last in exactly 2*(2^ADDR_W - 1) cycles.
- R8: Writes go to addresses 0 up to 2^ADDR_W - 1 in order, each exactly once. In the cycle after the write at the last address, `done` goes high. From then on `done` stays high, `wr_req` stays low and `rom_addr` stays at its maximum until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_full | input | 1 | Full flag from the FIFO write side |
| rom_addr | output | ADDR_W | Current ROM address |
| wr_req | output | 1 | FIFO write request; the word is captured at the next rising edge |
| wr_data | output | DATA_W | ROM word for `rom_addr`, wired to the FIFO data input |
| done | output | 1 | High once the whole table has been written |

## Verification
The hardest situation to reach is a full flag that rises exactly in the cycle after a write, while the new address is already showing. Only then does the block wait in its increment state instead of in idle. This must hold the address without skipping or repeating a word. The stimulus walks a table of full/not-full intervals of different lengths, including one-cycle pulses, against the free-running write cadence, so that stalls land in both waiting states and at many addresses. Separate directed runs hold the flag high across reset release, measure the span of an uninterrupted sweep, toggle the flag after completion, and reset in the middle of a sweep.

// File: rtl/rom_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the ROM-to-FIFO write sequencer.
// Assumes: nothing; holds only the state encoding.
package rom_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_INCADR = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rom_table.sv
`timescale 1ns/1ps
// Combinational lookup ROM holding a computed test table.
// Entry k = k * SEED + 1 (mod 2^DATA_W); entry 0 is therefore 1.
// Assumes: the reader uses the output in the same cycle (no output register).
module rom_table #(
    parameter int              DATA_W = 32,
    parameter int              ADDR_W = 8,
    parameter logic [DATA_W-1:0] SEED = DATA_W'(32'h9E37_79B9)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] table_q [DEPTH];

    // One constant per entry, computed at elaboration.
    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        localparam logic [DATA_W-1:0] ENT = DATA_W'(k) * SEED + DATA_W'(1);
        assign table_q[k] = ENT;
    end

    // Asynchronous read of the addressed entry.
    assign rd_data = table_q[addr];
endmodule

// File: rtl/addr_ctr.sv
`timescale 1ns/1ps
// ROM address register: clears on reset, steps by one on request.
// Assumes: the controller never asks for a step at the last address.
module addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    output logic [ADDR_W-1:0] addr_q,
    output logic              at_last
);
    // Address register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (inc_en) addr_q <= addr_q + ADDR_W'(1);
    end

    // Last-address flag for the controller.
    assign at_last = &addr_q;

    // R5
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(addr_q)) |-> (addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1))));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |-> !at_last);
endmodule

// File: rtl/wr_fsm.sv
`timescale 1ns/1ps
// Write controller: alternates a write cycle with an address-step cycle,
// waits on the FIFO full flag, and parks after the last address.
// Assumes: the full flag is synchronous to clk.
module wr_fsm
    import rom_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_full,
    input  logic at_last,
    output logic wr_req,
    output logic inc_en,
    output logic done
);
    seq_state_t state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (!fifo_full) state_d = ST_WRITE;
            ST_WRITE:  state_d = at_last ? ST_DONE : ST_INCADR;
            ST_INCADR: if (!fifo_full) state_d = ST_WRITE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Moore outputs; the address steps on the edge leaving a write.
    assign wr_req = (state_q == ST_WRITE);
    assign done   = (state_q == ST_DONE);
    assign inc_en = (state_q == ST_WRITE) && !at_last;

    // R6
    write_after_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !$past(fifo_full));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !wr_req));
endmodule

// File: rtl/rom_fifo_writer.sv
`timescale 1ns/1ps
// ROM-to-FIFO write sequencer top: streams every ROM entry, in address
// order, into a FIFO write port, one word at most every two clocks.
// Assumes: the FIFO registers wr_data when wr_req is high at a rising edge.
module rom_fifo_writer #(
    parameter int                DATA_W = 32,
    parameter int                ADDR_W = 8,
    parameter logic [DATA_W-1:0] SEED   = DATA_W'(32'h9E37_79B9)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_full,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              wr_req,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    logic inc_en;
    logic at_last;

    wr_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_full (fifo_full),
        .at_last   (at_last),
        .wr_req    (wr_req),
        .inc_en    (inc_en),
        .done      (done)
    );

    addr_ctr #(.ADDR_W(ADDR_W)) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (inc_en),
        .addr_q  (rom_addr),
        .at_last (at_last)
    );

    rom_table #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEED(SEED)) i_rom (
        .addr    (rom_addr),
        .rd_data (wr_data)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!wr_req && rom_addr == '0 && !done));

    // R4
    addr_held_for_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && $past(rst_n)) |-> $stable(rom_addr));

    // R8
    done_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&rom_addr));
endmodule

// File: tb/test_rom_fifo_writer.sv
`timescale 1ns/1ps
module test_rom_fifo_writer;
    localparam int          DW   = 32;
    localparam int          AW   = 8;
    localparam int          NW   = 1 << AW;
    localparam logic [31:0] SEED = 32'h9E37_79B9;
    localparam int          NROW = 10;
    localparam bit VEC_FULL [NROW] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int VEC_LEN  [NROW] = '{4, 9, 6, 2, 1, 1, 3, 50, 20, 700};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_full = 1'b0;
    logic [AW-1:0] rom_addr;
    logic          wr_req;
    logic [DW-1:0] wr_data;
    logic          done;

    int n_run = 0;
    int n_fail = 0;

    rom_fifo_writer #(.DATA_W(DW), .ADDR_W(AW), .SEED(SEED)) i_rom_fifo_writer (
        .clk(clk), .rst_n(rst_n), .fifo_full(fifo_full),
        .rom_addr(rom_addr), .wr_req(wr_req), .wr_data(wr_data), .done(done)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] exp_word(input int k);
        return 32'(k) * SEED + 32'd1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: values seen at the edge, then outputs checked at the falling edge.
    logic seen_full = 1'b0;
    logic seen_rst  = 1'b0;
    always @(posedge clk) begin
        seen_full <= fifo_full;
        seen_rst  <= rst_n;
    end

    int mon_wr, err_full, err_data, err_order, err_b2b, err_stab, err_inc, err_done, err_hold;
    int cyc = 0, first_cyc = 0, last_cyc = 0;
    logic          prev_wr = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    task automatic clear_stats();
        mon_wr = 0; err_full = 0; err_data = 0; err_order = 0; err_b2b = 0;
        err_stab = 0; err_inc = 0; err_done = 0; err_hold = 0;
        first_cyc = 0; last_cyc = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (seen_rst) begin
            if (wr_req) begin
                if (seen_full) err_full++;
                if (wr_data !== exp_word(int'(rom_addr))) err_data++;
                if (int'(rom_addr) != mon_wr) err_order++;
                if (prev_wr) err_b2b++;
                if (rom_addr !== prev_addr) err_stab++;
                if (done) err_done++;
                if (mon_wr == 0) first_cyc = cyc;
                last_cyc = cyc;
                mon_wr++;
            end
            if (prev_wr && prev_addr != {AW{1'b1}} && (wr_req || rom_addr !== prev_addr + AW'(1))) err_inc++;
            if (prev_wr && prev_addr == {AW{1'b1}} && !done) err_done++;
            if (seen_full && !prev_wr && rom_addr !== prev_addr) err_hold++;
        end else begin
            mon_wr = 0;
        end
        prev_wr   = wr_req;
        prev_addr = rom_addr;
    end

    task automatic apply_reset(input int n);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (n) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic report_sweep(input string tag);
        check(mon_wr == NW,   "R8", {tag, " words written"}, mon_wr, NW);
        check(err_order == 0, "R8", {tag, " out-of-order writes"}, err_order, 0);
        check(err_done == 0,  "R8", {tag, " done behaviour"}, err_done, 0);
        check(err_data == 0,  "R2", {tag, " data mismatches"}, err_data, 0);
        check(err_full == 0,  "R6", {tag, " writes after full"}, err_full, 0);
        check(err_hold == 0,  "R6", {tag, " address moved while full"}, err_hold, 0);
        check(err_b2b == 0,   "R7", {tag, " back-to-back writes"}, err_b2b, 0);
        check(err_stab == 0,  "R4", {tag, " address unstable at write"}, err_stab, 0);
        check(err_inc == 0,   "R5", {tag, " bad address step"}, err_inc, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clear_stats();
        // R1 reset state and R2 entry 0.
        fifo_full = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!wr_req && rom_addr == 0 && !done, "R1", "outputs in reset",
              {wr_req, done, rom_addr}, 0);
        check(wr_data == 32'd1, "R2", "entry 0", wr_data, 1);

        // R6: full high across reset release keeps idle; R3: first write.
        @(posedge clk); #1 rst_n = 1'b1;
        begin
            int bad = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (wr_req || rom_addr != 0) bad++;
            end
            check(bad == 0, "R6", "idle while full", bad, 0);
        end
        @(posedge clk); #1 fifo_full = 1'b0;
        @(negedge clk);
        check(!wr_req, "R3", "no write before sampling room", wr_req, 0);
        @(negedge clk);
        check(wr_req && rom_addr == 0, "R3", "first write after room",
              {wr_req, rom_addr}, 9'h100);

        // Vector table of full-flag intervals against a full sweep.
        clear_stats();
        apply_reset(2);
        for (int r = 0; r < NROW; r++) begin
            for (int c = 0; c < VEC_LEN[r]; c++) begin
                @(posedge clk); #1 fifo_full = VEC_FULL[r];
            end
        end
        @(negedge clk);
        report_sweep("stalled sweep");
        check(done, "R8", "done after stalled sweep", done, 1);

        // R7: uninterrupted sweep cadence.
        clear_stats();
        fifo_full = 1'b0;
        apply_reset(1);
        repeat (600) @(negedge clk);
        check(last_cyc - first_cyc == 2 * (NW - 1), "R7", "sweep span",
              last_cyc - first_cyc, 2 * (NW - 1));
        report_sweep("free sweep");

        // R8: after completion, toggling full causes nothing.
        begin
            int bad = 0;
            for (int i = 0; i < 12; i++) begin
                @(posedge clk); #1 fifo_full = i[0];
                @(negedge clk);
                if (wr_req || !done || rom_addr != {AW{1'b1}}) bad++;
            end
            check(bad == 0, "R8", "parked after done", bad, 0);
        end

        // R1: reset in the middle of a sweep.
        fifo_full = 1'b0;
        apply_reset(1);
        repeat (40) @(negedge clk);
        check(rom_addr != 0, "R1", "sweep under way before reset", rom_addr, 1);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!wr_req && rom_addr == 0 && !done, "R1", "mid-sweep reset",
              {wr_req, done, rom_addr}, 0);
        check(wr_data == 32'd1, "R2", "entry 0 after reset", wr_data, 1);
        @(negedge clk);
        check(wr_req && rom_addr == 0, "R3", "restart write", {wr_req, rom_addr}, 9'h100);
        @(negedge clk);
        check(!wr_req && rom_addr == 1 && wr_data == exp_word(1), "R5", "step after restart",
              rom_addr, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule